// File: doc/BRIEF.md
# Small-Page NAND Flash Read Responder

This block is a synthesizable device-side model of a small-page NAND flash that answers read traffic from a host flash controller. It sits on an 8-bit flash bus with command-latch and address-latch enables, active-low read and write strobes, and two active-low chip enables. One instance therefore behaves as two independent dies, each with its own read state, address pointer, error flag, ready output and page-organised storage of 528-byte pages.

A host selects a die, writes a read-mode command that chooses which third of the 528-byte page the column starts in, writes three address bytes, and then pulses the read strobe. Each read pulse returns the byte at the die's current linear address and advances that address by one, so a host can stream straight across page boundaries. The second address byte steps in units of 256 pages and the third selects the page inside that group. Storage locations that were never loaded, and addresses past the configured depth, read back as 0xFF.

The storage is filled through a separate valid/ready load stream before or between host transactions. A load beat transfers when `ld_valid` and `ld_ready` are both high in the same cycle. `ld_ready` drops for exactly the cycles in which the die named by `ld_die` takes a read strobe, and a held beat simply waits. `ld_valid` may be raised at any time and must stay high with stable fields until the beat transfers.

Top module: `pgf_rsp`

## Requirements
- R1: Die 0 is selected when `ce1_n` is low, whatever `ce2_n` is. Die 1 is selected only when `ce1_n` is high and `ce2_n` is low. With both high, the bus has no effect on any state or output.
- R2: A command byte is latched on a cycle where `we_n` falls (sampled high, then low) with `cle` high. Byte 0x00 selects read mode 1, 0x01 selects read mode 2 and 0x50 selects read mode 3. Each of these also clears the die's address-byte count. Byte 0xFF returns the die to idle.
- R3: The first address byte after a read-mode command sets the address to the byte plus a region offset: 0 in mode 1, 0x100 in mode 2 and 0x200 in mode 3.
- R4: The second address byte adds byte × 528 × 256 to the address. The third address byte adds byte × 528.
- R5: A read strobe is a falling `re_n` with `cle` and `ale` low. On the clock edge that samples it, `dout` takes the byte at the die's current linear address, where linear address = page × 528 + column, and the address then increments by one.
- R6: A location never loaded, or one at or beyond the storage depth (PAGES × 528 bytes per die), reads as 0xFF.
- R7: On a write-strobe fall with both `cle` and `ale` high, the byte is treated as a command, not as an address.
- R8: `err[d]` goes high and stays high until reset when die d receives an unknown command, an address byte while idle, or a fourth address byte. The die's mode, count and address are left unchanged.
- R9: `dout_oe` is a registered output. It is high in the cycle after an edge that sampled a selected die with `re_n` low, and low otherwise, including after reset.
- R10: `rdy[d]` is 0 after reset and goes to 1 once die d is selected with both `re_n` and `we_n` high.
- R11: A load beat writes `ld_data` into die `ld_die` at index `ld_idx` when `ld_valid` and `ld_ready` are both high. `ld_ready` is low exactly when that die takes a read strobe in the same cycle.
- R12: The two dies keep separate modes, address pointers and contents. Traffic to one die leaves the other die's read position unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce1_n | input | 1 | Chip enable of die 0, active low, priority |
| ce2_n | input | 1 | Chip enable of die 1, active low |
| cle | input | 1 | Command-latch enable |
| ale | input | 1 | Address-latch enable |
| re_n | input | 1 | Read strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| din | input | 8 | Bus byte from host |
| dout | output | 8 | Read byte toward host |
| dout_oe | output | 1 | Registered drive enable for dout |
| rdy | output | 2 | Ready per die |
| err | output | 2 | Sticky protocol error per die |
| ld_valid | input | 1 | Load beat valid |
| ld_ready | output | 1 | Load beat ready |
| ld_die | input | 1 | Die targeted by load beat |
| ld_idx | input | IDX_W | Byte index in die storage |
| ld_data | input | 8 | Byte to load |

## Verification
The bench builds the block with PAGES = 3, so each die holds 1584 bytes. With this depth, all three column regions, page-crossing reads and third-byte page values of 0 to 2 land in real storage. Any non-zero second address byte jumps past the depth and exercises the 0xFF fallback. Loading only part of each die leaves unloaded spans inside the storage, so the two sources of 0xFF can be told apart.

// File: rtl/pgf_pkg.sv
package pgf_pkg;
  localparam int PAGE_BYTES = 528;
  localparam int PAGE_GROUP = 256;
  localparam int ADDR_W     = 26;

  localparam logic [7:0] CMD_IDLE = 8'hFF;
  localparam logic [7:0] CMD_RD1  = 8'h00;
  localparam logic [7:0] CMD_RD2  = 8'h01;
  localparam logic [7:0] CMD_RD3  = 8'h50;

  typedef enum logic [1:0] {M_IDLE, M_RD1, M_RD2, M_RD3} rmode_e;

  function automatic logic [ADDR_W-1:0] region_base(rmode_e m);
    case (m)
      M_RD2:   return ADDR_W'(12'h100);
      M_RD3:   return ADDR_W'(12'h200);
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/pgf_bus_front.sv
module pgf_bus_front (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ce1_n,
  input  logic       ce2_n,
  input  logic       cle,
  input  logic       ale,
  input  logic       re_n,
  input  logic       we_n,
  output logic [1:0] sel,
  output logic [1:0] cmd_ev,
  output logic [1:0] adr_ev,
  output logic [1:0] rd_ev,
  output logic [1:0] idle_ev
);
  logic re_q, we_q;
  logic we_fall, re_fall;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      re_q <= 1'b1;
      we_q <= 1'b1;
    end else begin
      re_q <= re_n;
      we_q <= we_n;
    end
  end

  always_comb begin
    sel[0]  = !ce1_n;
    sel[1]  = ce1_n && !ce2_n;
    we_fall = we_q && !we_n;
    re_fall = re_q && !re_n;
    cmd_ev  = sel & {2{we_fall && cle}};
    adr_ev  = sel & {2{we_fall && !cle && ale}};
    rd_ev   = sel & {2{re_fall && !cle && !ale}};
    idle_ev = sel & {2{re_n && we_n}};
  end
endmodule

// File: rtl/pgf_die_ctl.sv
module pgf_die_ctl
  import pgf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_ev,
  input  logic              adr_ev,
  input  logic              rd_ev,
  input  logic [7:0]        din,
  output logic [ADDR_W-1:0] addr,
  output logic              err
);
  localparam logic [ADDR_W-1:0] GROUP_STEP = ADDR_W'(PAGE_BYTES * PAGE_GROUP);
  localparam logic [ADDR_W-1:0] PAGE_STEP  = ADDR_W'(PAGE_BYTES);

  rmode_e     mode;
  logic [1:0] acyc;
  logic       known_cmd;

  always_comb begin
    known_cmd = (din == CMD_IDLE) || (din == CMD_RD1) ||
                (din == CMD_RD2)  || (din == CMD_RD3);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= M_IDLE;
      acyc <= '0;
      addr <= '0;
      err  <= 1'b0;
    end else if (cmd_ev) begin
      case (din)
        CMD_IDLE: mode <= M_IDLE;
        CMD_RD1:  begin mode <= M_RD1; acyc <= '0; end
        CMD_RD2:  begin mode <= M_RD2; acyc <= '0; end
        CMD_RD3:  begin mode <= M_RD3; acyc <= '0; end
        default:  err <= 1'b1;
      endcase
    end else if (adr_ev) begin
      if (mode == M_IDLE || acyc == 2'd3) begin
        err <= 1'b1;
      end else begin
        case (acyc)
          2'd0:    addr <= ADDR_W'(din) + region_base(mode);
          2'd1:    addr <= addr + ADDR_W'(din) * GROUP_STEP;
          default: addr <= addr + ADDR_W'(din) * PAGE_STEP;
        endcase
        acyc <= acyc + 2'd1;
      end
    end else if (rd_ev) begin
      addr <= addr + ADDR_W'(1);
    end
  end

  // R8: error flag never clears outside reset
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err) else $error("err dropped");

  // R8: unknown command leaves mode and count alone
  p_bad_cmd_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ev && !known_cmd) |=> ($stable(mode) && $stable(acyc) && err))
    else $error("bad command changed state");

  // R5: a read strobe advances the pointer by one
  p_rd_inc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ev && !cmd_ev && !adr_ev) |=> addr == $past(addr) + ADDR_W'(1))
    else $error("address did not advance");

  // R2: mode 2 command lands in mode 2 with zero count
  p_mode2_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ev && din == CMD_RD2) |=> (mode == M_RD2 && acyc == 2'd0))
    else $error("mode 2 entry wrong");
endmodule

// File: rtl/pgf_store.sv
module pgf_store
  import pgf_pkg::*;
#(
  parameter int DEPTH = 1056,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);
  logic [7:0]       mem [DEPTH];
  logic [DEPTH-1:0] vld;
  logic             wr_ok;
  logic             in_range;
  logic [IDX_W-1:0] rd_idx;

  always_comb begin
    wr_ok    = wr_en && (int'(wr_idx) < DEPTH);
    in_range = rd_addr < ADDR_W'(DEPTH);
    rd_idx   = rd_addr[IDX_W-1:0];
    rd_data  = (in_range && vld[rd_idx]) ? mem[rd_idx] : 8'hFF;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) vld <= '0;
    else if (wr_ok) vld[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_idx] <= wr_data;
  end

  // R11: an accepted load marks its location as filled
  p_load_marks_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |=> vld[$past(wr_idx)]) else $error("load not recorded");
endmodule

// File: rtl/pgf_rsp.sv
module pgf_rsp
  import pgf_pkg::*;
#(
  parameter int PAGES = 2,
  localparam int DEPTH = PAGES * PAGE_BYTES,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce1_n,
  input  logic             ce2_n,
  input  logic             cle,
  input  logic             ale,
  input  logic             re_n,
  input  logic             we_n,
  input  logic [7:0]       din,
  output logic [7:0]       dout,
  output logic             dout_oe,
  output logic [1:0]       rdy,
  output logic [1:0]       err,
  input  logic             ld_valid,
  output logic             ld_ready,
  input  logic             ld_die,
  input  logic [IDX_W-1:0] ld_idx,
  input  logic [7:0]       ld_data
);
  localparam int NDIE = 2;

  logic [NDIE-1:0]   sel, cmd_ev, adr_ev, rd_ev, idle_ev;
  logic [ADDR_W-1:0] die_addr [NDIE];
  logic [7:0]        die_byte [NDIE];
  logic              ld_fire;

  pgf_bus_front u_front (
    .clk(clk), .rst_n(rst_n), .ce1_n(ce1_n), .ce2_n(ce2_n),
    .cle(cle), .ale(ale), .re_n(re_n), .we_n(we_n),
    .sel(sel), .cmd_ev(cmd_ev), .adr_ev(adr_ev), .rd_ev(rd_ev),
    .idle_ev(idle_ev)
  );

  always_comb begin
    ld_ready = !rd_ev[ld_die];
    ld_fire  = ld_valid && ld_ready;
  end

  for (genvar d = 0; d < NDIE; d++) begin : g_die
    pgf_die_ctl u_ctl (
      .clk(clk), .rst_n(rst_n),
      .cmd_ev(cmd_ev[d]), .adr_ev(adr_ev[d]), .rd_ev(rd_ev[d]),
      .din(din), .addr(die_addr[d]), .err(err[d])
    );

    pgf_store #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
      .clk(clk), .rst_n(rst_n),
      .wr_en(ld_fire && (ld_die == 1'(d))),
      .wr_idx(ld_idx), .wr_data(ld_data),
      .rd_addr(die_addr[d]), .rd_data(die_byte[d])
    );

    always_ff @(posedge clk) begin
      if (!rst_n) rdy[d] <= 1'b0;
      else if (idle_ev[d]) rdy[d] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout    <= '0;
      dout_oe <= 1'b0;
    end else begin
      dout_oe <= (|sel) && !re_n;
      if (rd_ev[0])      dout <= die_byte[0];
      else if (rd_ev[1]) dout <= die_byte[1];
    end
  end

  // R9: drive enable only follows a selected, low read strobe
  p_oe_follows_re_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dout_oe |-> $past(!re_n && (!ce1_n || !ce2_n)))
    else $error("dout_oe without read strobe");

  // R1: an unselected bus changes no error flag or ready
  p_ignore_bus_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ce1_n && ce2_n) |=> ($stable(err) && $stable(rdy)))
    else $error("unselected bus had effect");

  // R10: ready stays asserted once reached
  p_rdy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rdy[0] |=> rdy[0]) else $error("rdy[0] dropped");
endmodule

// File: tb/sim_pgf_rsp.sv
`timescale 1ns/1ps
module sim_pgf_rsp;
  localparam int TB_PAGES = 3;
  localparam int TB_DEPTH = TB_PAGES * 528;
  localparam int TB_IDX_W = $clog2(TB_DEPTH);
  localparam int LIM0 = 1200;
  localparam int LIM1 = 800;

  // fields: die, command, first address byte, third address byte
  localparam logic [31:0] VEC [8] = '{
    {8'd0, 8'h00, 8'h05, 8'd0},
    {8'd0, 8'h01, 8'h10, 8'd1},
    {8'd0, 8'h50, 8'h0F, 8'd0},
    {8'd1, 8'h00, 8'hFE, 8'd1},
    {8'd1, 8'h50, 8'h00, 8'd2},
    {8'd0, 8'h00, 8'h00, 8'd2},
    {8'd0, 8'h50, 8'h0F, 8'd2},
    {8'd1, 8'h01, 8'h20, 8'd0}
  };

  logic clk = 0, rst_n = 0;
  logic ce1_n = 1, ce2_n = 1, cle = 0, ale = 0, re_n = 1, we_n = 1;
  logic [7:0] din = 0;
  logic [7:0] dout;
  logic dout_oe, ld_ready;
  logic [1:0] rdy, err;
  logic ld_valid = 0, ld_die = 0;
  logic [TB_IDX_W-1:0] ld_idx = 0;
  logic [7:0] ld_data = 0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pgf_rsp #(.PAGES(TB_PAGES)) u0 (
    .clk(clk), .rst_n(rst_n), .ce1_n(ce1_n), .ce2_n(ce2_n), .cle(cle),
    .ale(ale), .re_n(re_n), .we_n(we_n), .din(din), .dout(dout),
    .dout_oe(dout_oe), .rdy(rdy), .err(err), .ld_valid(ld_valid),
    .ld_ready(ld_ready), .ld_die(ld_die), .ld_idx(ld_idx), .ld_data(ld_data)
  );

  function automatic logic [7:0] pat(int die, int idx);
    if (die == 0) return 8'((idx * 7 + 3) & 255);
    return 8'((idx * 13 + 90) & 255);
  endfunction

  function automatic logic [7:0] model(int die, int idx);
    if (idx < ((die == 0) ? LIM0 : LIM1)) return pat(die, idx);
    return 8'hFF;
  endfunction

  function automatic int region(logic [7:0] c);
    if (c == 8'h01) return 256;
    if (c == 8'h50) return 512;
    return 0;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pick(input int die);
    ce1_n = !(die == 0 || die == 2);
    ce2_n = !(die == 1 || die == 2);
  endtask

  task automatic wr(input int die, input logic c, input logic a, input logic [7:0] b);
    @(negedge clk); pick(die); cle = c; ale = a; din = b; we_n = 0;
    @(negedge clk); we_n = 1; cle = 0; ale = 0;
  endtask

  task automatic rd(input int die, output logic [7:0] b, output logic oe);
    @(negedge clk); pick(die); re_n = 0;
    @(negedge clk); b = dout; oe = dout_oe; re_n = 1;
  endtask

  task automatic seq(input int die, input logic [7:0] c, input logic [7:0] a0,
                     input logic [7:0] a1, input logic [7:0] a2);
    wr(die, 1, 0, c); wr(die, 0, 1, a0); wr(die, 0, 1, a1); wr(die, 0, 1, a2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    logic oe;
    int base;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R9 reset oe", {7'd0, dout_oe}, 8'd0);
    chk("R10 reset rdy", {6'd0, rdy}, 8'd0);
    chk("R8 reset err", {6'd0, err}, 8'd0);

    for (int i = 0; i < LIM0; i++) begin
      @(negedge clk); ld_valid = 1; ld_die = 0; ld_idx = TB_IDX_W'(i); ld_data = pat(0, i);
    end
    for (int i = 0; i < LIM1; i++) begin
      @(negedge clk); ld_valid = 1; ld_die = 1; ld_idx = TB_IDX_W'(i); ld_data = pat(1, i);
    end
    @(negedge clk); ld_valid = 0;

    // R10: ready per die once idle-selected
    pick(0); @(negedge clk);
    chk("R10 rdy die0", {6'd0, rdy}, 8'b01);
    pick(1); @(negedge clk);
    chk("R10 rdy die1", {6'd0, rdy}, 8'b11);
    pick(3);

    // R3 R4 R5 R6 R12: vector table
    for (int v = 0; v < 8; v++) begin
      seq(int'(VEC[v][31:24]), VEC[v][23:16], VEC[v][15:8], 8'd0, VEC[v][7:0]);
      base = region(VEC[v][23:16]) + int'(VEC[v][15:8]) + int'(VEC[v][7:0]) * 528;
      for (int k = 0; k < 3; k++) begin
        rd(int'(VEC[v][31:24]), b, oe);
        chk("R5 R3 R4 R6 table read", b, model(int'(VEC[v][31:24]), base + k));
        if (k == 0) chk("R9 oe during read", {7'd0, oe}, 8'd1);
      end
    end
    @(negedge clk);
    chk("R9 oe released", {7'd0, dout_oe}, 8'd0);

    // R1: unselected bus ignored
    wr(3, 1, 0, 8'h33);
    chk("R1 ignored cmd err", {6'd0, err}, 8'd0);
    rd(3, b, oe);
    chk("R1 ignored read oe", {7'd0, oe}, 8'd0);

    // R1: both enables low -> die 0 only
    wr(2, 1, 0, 8'h33);
    chk("R1 priority err", {6'd0, err}, 8'b01);

    // R2 R8: reset command then address byte while idle
    wr(1, 1, 0, 8'hFF);
    wr(1, 0, 1, 8'h00);
    chk("R2 R8 idle address err", {6'd0, err}, 8'b11);

    // R8: fourth address byte leaves pointer unchanged
    seq(1, 8'h00, 8'h03, 8'h00, 8'h00);
    wr(1, 0, 1, 8'h40);
    rd(1, b, oe);
    chk("R8 fourth byte ignored", b, model(1, 3));

    // R8: unknown command mid-sequence keeps count
    wr(0, 1, 0, 8'h01); wr(0, 0, 1, 8'h02);
    wr(0, 1, 0, 8'h77);
    wr(0, 0, 1, 8'h00); wr(0, 0, 1, 8'h01);
    rd(0, b, oe);
    chk("R8 bad cmd keeps count", b, model(0, 256 + 2 + 528));

    // R7: cle wins over ale
    wr(0, 1, 1, 8'h50);
    wr(0, 0, 1, 8'h04); wr(0, 0, 1, 8'h00); wr(0, 0, 1, 8'h00);
    rd(0, b, oe);
    chk("R7 cle priority", b, model(0, 516));

    // R4 R6: second address byte jumps past depth
    seq(0, 8'h00, 8'h00, 8'h01, 8'h00);
    rd(0, b, oe);
    chk("R4 R6 group step beyond depth", b, 8'hFF);

    // R12: die 1 position survives die 0 traffic
    seq(1, 8'h00, 8'h10, 8'h00, 8'h00);
    rd(1, b, oe);
    chk("R12 die1 first", b, model(1, 16));
    seq(0, 8'h00, 8'h08, 8'h00, 8'h00);
    rd(0, b, oe);
    chk("R12 die0 between", b, model(0, 8));
    rd(1, b, oe);
    chk("R12 die1 continues", b, model(1, 17));

    // R11: ready drops only for the die taking a read strobe
    @(negedge clk); pick(0); re_n = 0; ld_die = 0; #1;
    chk("R11 ready low same die", {7'd0, ld_ready}, 8'd0);
    ld_die = 1; #1;
    chk("R11 ready high other die", {7'd0, ld_ready}, 8'd1);
    @(negedge clk); re_n = 1; pick(3);

    // R11: late load into die 1 becomes readable
    @(negedge clk); ld_valid = 1; ld_die = 1; ld_idx = TB_IDX_W'(896); ld_data = 8'h3C;
    @(negedge clk); ld_valid = 0;
    seq(1, 8'h01, 8'h70, 8'h00, 8'h01);
    rd(1, b, oe);
    chk("R11 loaded byte read", b, 8'h3C);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule